// File: doc/BRIEF.md
# Byte DMA Channel with Data-Terminated Blocks

This block is one byte-wide DMA channel. It copies bytes from a source buffer to a destination buffer through a single request/acknowledge memory port. Each byte takes one read handshake and then one write handshake. Software programs the following through a small word-addressed register port:

- the two start addresses;
- a source length, a destination length and a cell length;
- a stop byte;
- the control bits.

Each trigger moves one cell. A trigger is either a software force-start or, when enabled, a pulse on the hardware start input.

A block ends once the larger of the two lengths has been copied. The shorter side wraps back to its start address. When stop-byte matching is on, a copied byte equal to the stop byte ends the block at once. The byte itself is still written. This makes the channel suited to carriage-return-terminated text.

Either kind of block end follows the same completion path. It sets the block flag, clears the enable unless auto-rearm is set, and returns both pointers to their start addresses. Three sticky flags (cell end, block end, abort) are cleared by writing 1. Each flag has its own enable, and together they drive one interrupt line.

Top module: `dma_patchan`

Register map (word address on `cfg_waddr`/`cfg_raddr`):

| Address | Contents |
|---|---|
| 0 | CTRL |
| 1 | stop byte in bits [7:0] |
| 2 | source start address |
| 3 | destination start address |
| 4 | source length |
| 5 | destination length |
| 6 | cell length |
| 7 | FLAGS |
| 8 | interrupt enables, same bit order as FLAGS |

CTRL bits:

| Bit | Meaning |
|---|---|
| 0 | enable |
| 1 | auto-rearm |
| 2 | stop-byte match on |
| 3 | force-start (write-only, reads 0) |
| 4 | hardware start input honoured |

FLAGS bits:

| Bit | Meaning |
|---|---|
| 0 | cell end |
| 1 | block end |
| 2 | abort |

All lengths must be nonzero.

## Requirements
- R1: After reset all registers read 0, `irq` is low and `mem_req` is low.
- R2: Writing CTRL with bit 0 and bit 3 set starts a cell when the channel is idle. Each byte is a read of the source address (`mem_we`=0) followed by a write of that byte to the destination address (`mem_we`=1). With an always-ready memory, a cell of N bytes sets FLAGS bit 0 on the 2N+1-th clock edge after the edge that takes the CTRL write.
- R3: A block ends after max(source length, destination length) bytes. Destination byte k (modulo its length) receives source byte k (modulo the source length). Block end sets FLAGS bit 1 and FLAGS bit 0.
- R4: With CTRL bit 2 set, the first copied byte equal to the stop byte (address 1, bits [7:0]) is written to the destination and then ends the block, exactly as R3 and R6 describe.
- R5: With CTRL bit 2 clear, bytes equal to the stop byte do not shorten the block.
- R6: With CTRL bit 1 clear, block end clears CTRL bit 0. With CTRL bit 1 set, CTRL bit 0 stays set, and the next trigger starts again at both start addresses.
- R7: A block longer than the cell length ends a cell with FLAGS bit 0 set, FLAGS bit 1 clear and CTRL bit 0 still set. Later triggers continue the block from where it stopped.
- R8: With CTRL bit 4 set, a one-cycle pulse on `start_evt` starts a cell, and FLAGS bit 0 is due on the 2N-th edge after the edge that sees the pulse. With CTRL bit 4 clear, `start_evt` has no effect.
- R9: Writes to the stop byte, addresses, lengths or CTRL bit 2 while CTRL bit 0 is set take effect only at the next 0-to-1 change of CTRL bit 0.
- R10: Clearing CTRL bit 0 during a cell drops `mem_req` in the next cycle, stops the transfer and sets FLAGS bit 2.
- R11: Writing 1 to a FLAGS bit clears it; writing 0 leaves it unchanged. `irq` is high exactly when some FLAGS bit and its enable bit at address 8 are both set.
- R12: A trigger that arrives while a cell is in progress is ignored and does not queue a further cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 4 | Register write word address |
| cfg_wdata | input | 16 | Register write data |
| cfg_raddr | input | 4 | Register read word address |
| cfg_rdata | output | 16 | Register read data, combinational from `cfg_raddr` |
| start_evt | input | 1 | Hardware start pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write handshake, 0 for a read |
| mem_addr | output | 16 | Byte address of the handshake |
| mem_wdata | output | 8 | Byte being written |
| mem_rdata | input | 8 | Byte returned on a read acknowledge |
| mem_ack | input | 1 | Memory acknowledge; the handshake completes on the edge where `mem_req` and `mem_ack` are both high |
| irq | output | 1 | Channel interrupt |

## Verification
With a memory that acknowledges in the same cycle, a software-started cell of N bytes raises its flag 2N+1 edges after the CTRL write edge. A hardware-started cell raises it after 2N edges, one fewer, because the pulse is seen directly. An abort flag follows the disabling write by one edge, and `mem_req` is already low after that write edge. The bench drives inputs and samples outputs on falling edges. It counts exactly those edge totals and checks each flag one edge before it is due and again on the edge it is due. Destination contents are compared only after the block has ended.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int REG_W  = 16;
    localparam int RA_W   = 4;
    localparam int BYTE_W = 8;
    localparam int NFLAG  = 3;

    localparam logic [RA_W-1:0] RA_CTRL = 4'd0;
    localparam logic [RA_W-1:0] RA_PAT  = 4'd1;
    localparam logic [RA_W-1:0] RA_SRC  = 4'd2;
    localparam logic [RA_W-1:0] RA_DST  = 4'd3;
    localparam logic [RA_W-1:0] RA_SLEN = 4'd4;
    localparam logic [RA_W-1:0] RA_DLEN = 4'd5;
    localparam logic [RA_W-1:0] RA_CLEN = 4'd6;
    localparam logic [RA_W-1:0] RA_FLAG = 4'd7;
    localparam logic [RA_W-1:0] RA_IEN  = 4'd8;

    localparam int C_EN    = 0;
    localparam int C_AUTO  = 1;
    localparam int C_PAT   = 2;
    localparam int C_FORCE = 3;
    localparam int C_EVT   = 4;

    localparam int F_CELL = 0;
    localparam int F_BLK  = 1;
    localparam int F_ABT  = 2;

    typedef struct packed {
        logic               pat_en;
        logic [BYTE_W-1:0]  pat;
        logic [ADDR_W-1:0]  src_base;
        logic [ADDR_W-1:0]  dst_base;
        logic [LEN_W-1:0]   src_len;
        logic [LEN_W-1:0]   dst_len;
        logic [LEN_W-1:0]   cell_len;
    } xfer_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } eng_st_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [RA_W-1:0]  rd_addr,
    input  logic             blk_done,
    output logic [REG_W-1:0] rd_data,
    output logic             en_o,
    output logic             auto_o,
    output logic             evt_en_o,
    output logic             force_o,
    output xfer_cfg_t        act_o
);
    typedef struct packed {
        logic               en;
        logic               auto_en;
        logic               pat_en;
        logic               evt_en;
        logic               force_p;
        logic [BYTE_W-1:0]  pat;
        logic [ADDR_W-1:0]  src_base;
        logic [ADDR_W-1:0]  dst_base;
        logic [LEN_W-1:0]   src_len;
        logic [LEN_W-1:0]   dst_len;
        logic [LEN_W-1:0]   cell_len;
        xfer_cfg_t          act;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.force_p = 1'b0;
        if (blk_done && !r_q.auto_en) begin
            r_d.en = 1'b0;
        end
        if (wr_en) begin
            unique case (wr_addr)
                RA_CTRL: begin
                    r_d.en      = wr_data[C_EN];
                    r_d.auto_en = wr_data[C_AUTO];
                    r_d.pat_en  = wr_data[C_PAT];
                    r_d.evt_en  = wr_data[C_EVT];
                    r_d.force_p = wr_data[C_FORCE];
                end
                RA_PAT:  r_d.pat      = wr_data[BYTE_W-1:0];
                RA_SRC:  r_d.src_base = wr_data[ADDR_W-1:0];
                RA_DST:  r_d.dst_base = wr_data[ADDR_W-1:0];
                RA_SLEN: r_d.src_len  = wr_data[LEN_W-1:0];
                RA_DLEN: r_d.dst_len  = wr_data[LEN_W-1:0];
                RA_CLEN: r_d.cell_len = wr_data[LEN_W-1:0];
                default: ;
            endcase
        end
        // working copy is refreshed only when the channel turns on
        if (!r_q.en && r_d.en) begin
            r_d.act.pat_en   = r_d.pat_en;
            r_d.act.pat      = r_d.pat;
            r_d.act.src_base = r_d.src_base;
            r_d.act.dst_base = r_d.dst_base;
            r_d.act.src_len  = r_d.src_len;
            r_d.act.dst_len  = r_d.dst_len;
            r_d.act.cell_len = r_d.cell_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            RA_CTRL: begin
                rd_data[C_EN]   = r_q.en;
                rd_data[C_AUTO] = r_q.auto_en;
                rd_data[C_PAT]  = r_q.pat_en;
                rd_data[C_EVT]  = r_q.evt_en;
            end
            RA_PAT:  rd_data = REG_W'(r_q.pat);
            RA_SRC:  rd_data = REG_W'(r_q.src_base);
            RA_DST:  rd_data = REG_W'(r_q.dst_base);
            RA_SLEN: rd_data = REG_W'(r_q.src_len);
            RA_DLEN: rd_data = REG_W'(r_q.dst_len);
            RA_CLEN: rd_data = REG_W'(r_q.cell_len);
            default: rd_data = '0;
        endcase
    end

    assign en_o     = r_q.en;
    assign auto_o   = r_q.auto_en;
    assign evt_en_o = r_q.evt_en;
    assign force_o  = r_q.force_p;
    assign act_o    = r_q.act;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              trig,
    input  xfer_cfg_t         cfg,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              cell_done,
    output logic              blk_done,
    output logic              abort
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        eng_st_e            st;
        logic [LEN_W-1:0]   src_off;
        logic [LEN_W-1:0]   dst_off;
        logic [LEN_W-1:0]   blk_cnt;
        logic [LEN_W-1:0]   cell_cnt;
        logic [BYTE_W-1:0]  data;
    } eng_t;

    eng_t e_d, e_q;
    logic [LEN_W-1:0] blk_len, blk_next, src_next, dst_next;
    logic             hit;

    always_comb begin
        blk_len  = (cfg.src_len > cfg.dst_len) ? cfg.src_len : cfg.dst_len;
        blk_next = e_q.blk_cnt + ONE;
        src_next = (e_q.src_off + ONE == cfg.src_len) ? '0 : e_q.src_off + ONE;
        dst_next = (e_q.dst_off + ONE == cfg.dst_len) ? '0 : e_q.dst_off + ONE;
        hit      = cfg.pat_en && (e_q.data == cfg.pat);

        e_d       = e_q;
        cell_done = 1'b0;
        blk_done  = 1'b0;
        abort     = 1'b0;

        if (!en) begin
            abort = (e_q.st != ST_IDLE);
            e_d   = '0;
        end else begin
            unique case (e_q.st)
                ST_IDLE: begin
                    if (trig) begin
                        e_d.st       = ST_RD;
                        e_d.cell_cnt = '0;
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        e_d.data = mem_rdata;
                        e_d.st   = ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        e_d.cell_cnt = e_q.cell_cnt + ONE;
                        e_d.blk_cnt  = blk_next;
                        e_d.src_off  = src_next;
                        e_d.dst_off  = dst_next;
                        if (hit || blk_next == blk_len) begin
                            blk_done    = 1'b1;
                            cell_done   = 1'b1;
                            e_d.st      = ST_IDLE;
                            e_d.src_off = '0;
                            e_d.dst_off = '0;
                            e_d.blk_cnt = '0;
                        end else if (e_d.cell_cnt == cfg.cell_len) begin
                            cell_done = 1'b1;
                            e_d.st    = ST_IDLE;
                        end else begin
                            e_d.st = ST_RD;
                        end
                    end
                end
                default: e_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign mem_req   = en && (e_q.st != ST_IDLE);
    assign mem_we    = (e_q.st == ST_WR);
    assign mem_addr  = (e_q.st == ST_WR) ? cfg.dst_base + ADDR_W'(e_q.dst_off)
                                          : cfg.src_base + ADDR_W'(e_q.src_off);
    assign mem_wdata = e_q.data;
endmodule

// File: rtl/dma_irq.sv
module dma_irq
    import dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  wr_addr,
    input  logic [NFLAG-1:0] wr_bits,
    input  logic             cell_done,
    input  logic             blk_done,
    input  logic             abort,
    output logic [NFLAG-1:0] flags_o,
    output logic [NFLAG-1:0] ien_o,
    output logic             irq
);
    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NFLAG-1:0] ien;
    } irq_t;

    irq_t i_d, i_q;
    logic [NFLAG-1:0] ev;

    always_comb begin
        ev         = '0;
        ev[F_CELL] = cell_done;
        ev[F_BLK]  = blk_done;
        ev[F_ABT]  = abort;
        i_d = i_q;
        if (wr_en && wr_addr == RA_FLAG) i_d.flags = i_q.flags & ~wr_bits;
        if (wr_en && wr_addr == RA_IEN)  i_d.ien   = wr_bits;
        i_d.flags = i_d.flags | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign flags_o = i_q.flags;
    assign ien_o   = i_q.ien;
    assign irq     = |(i_q.flags & i_q.ien);
endmodule

// File: rtl/dma_patchan.sv
module dma_patchan
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RA_W-1:0]   cfg_waddr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic [RA_W-1:0]   cfg_raddr,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              start_evt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              irq
);
    logic             en_q, auto_en, evt_en, force_p, trig;
    logic             cell_done, blk_done, abort;
    logic [REG_W-1:0] reg_rd;
    logic [NFLAG-1:0] flags, ien;
    xfer_cfg_t        act;

    dma_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_waddr),
        .wr_data  (cfg_wdata),
        .rd_addr  (cfg_raddr),
        .blk_done (blk_done),
        .rd_data  (reg_rd),
        .en_o     (en_q),
        .auto_o   (auto_en),
        .evt_en_o (evt_en),
        .force_o  (force_p),
        .act_o    (act)
    );

    assign trig = force_p || (evt_en && start_evt);

    dma_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .trig      (trig),
        .cfg       (act),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cell_done (cell_done),
        .blk_done  (blk_done),
        .abort     (abort)
    );

    dma_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_waddr),
        .wr_bits   (cfg_wdata[NFLAG-1:0]),
        .cell_done (cell_done),
        .blk_done  (blk_done),
        .abort     (abort),
        .flags_o   (flags),
        .ien_o     (ien),
        .irq       (irq)
    );

    always_comb begin
        unique case (cfg_raddr)
            RA_FLAG: cfg_rdata = REG_W'(flags);
            RA_IEN:  cfg_rdata = REG_W'(ien);
            default: cfg_rdata = reg_rd;
        endcase
    end
endmodule

// File: rtl/dma_patchan_chk.sv
module dma_patchan_chk
    import dma_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [RA_W-1:0]  cfg_waddr,
    input logic             mem_req,
    input logic             mem_we,
    input logic             en_q,
    input logic             auto_en,
    input logic             cell_done,
    input logic             blk_done,
    input logic             abort,
    input logic [NFLAG-1:0] flags,
    input logic [NFLAG-1:0] ien,
    input logic             irq
);
    logic ctrl_wr;
    assign ctrl_wr = cfg_we && (cfg_waddr == RA_CTRL);

    p_req_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> en_q);
    p_blk_clears_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !auto_en && !ctrl_wr) |=> !en_q);
    p_blk_keeps_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && auto_en && !ctrl_wr) |=> en_q);
    p_cell_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cell_done |=> flags[F_CELL]);
    p_abort_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> flags[F_ABT]);
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
    p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req));
    p_blk_closes_cell_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> cell_done);
endmodule

bind dma_patchan dma_patchan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_waddr (cfg_waddr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .en_q      (en_q),
    .auto_en   (auto_en),
    .cell_done (cell_done),
    .blk_done  (blk_done),
    .abort     (abort),
    .flags     (flags),
    .ien       (ien),
    .irq       (irq)
);

// File: tb/dma_patchan_tb_top.sv
module dma_patchan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_waddr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  cfg_raddr = '0;
    logic [15:0] cfg_rdata;
    logic        start_evt = 1'b0;
    logic        mem_req, mem_we, mem_ack, irq;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        fill_go = 1'b0;
    logic [7:0]  mem [256];
    int          checks = 0;
    int          errs = 0;

    always #2 clk = ~clk;

    dma_patchan dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .start_evt(start_evt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .irq(irq)
    );

    function automatic logic [7:0] srcval(int i);
        return (i == 5) ? 8'h0D : 8'(32'h20 + i);
    endfunction

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (fill_go) begin
            for (int i = 0; i < 256; i++) mem[i] <= (i < 64) ? srcval(i) : 8'hEE;
        end else if (mem_req && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    localparam logic [15:0] DBASE = 16'h0080;

    typedef struct packed {
        logic [11:0] sl;
        logic [11:0] dl;
        logic        pe;
        logic [7:0]  pat;
        logic [7:0]  nexp;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{12'd4, 12'd4, 1'b0, 8'h0D, 8'd4},
        '{12'd8, 12'd8, 1'b1, 8'h0D, 8'd6},
        '{12'd8, 12'd8, 1'b1, 8'h77, 8'd8},
        '{12'd3, 12'd6, 1'b0, 8'h00, 8'd6},
        '{12'd6, 12'd2, 1'b0, 8'h00, 8'd6},
        '{12'd8, 12'd8, 1'b0, 8'h0D, 8'd8},
        '{12'd8, 12'd8, 1'b1, 8'h20, 8'd1}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        cfg_raddr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic fill();
        fill_go = 1'b1;
        @(negedge clk);
        fill_go = 1'b0;
    endtask

    task automatic setup(logic [11:0] sl, logic [11:0] dl, logic [11:0] cl, logic [7:0] pat);
        wr(4'd2, 16'h0000); wr(4'd3, DBASE);
        wr(4'd4, 16'(sl));  wr(4'd5, 16'(dl));
        wr(4'd6, 16'(cl));  wr(4'd1, 16'(pat));
        wr(4'd7, 16'h0007);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        logic [7:0]  expd [16];
        int          mism;
        string       tag;

        repeat (3) @(negedge clk);
        rd(4'd0, rv); check("R1 ctrl", rv, 0);
        rd(4'd7, rv); check("R1 flags", rv, 0);
        rd(4'd4, rv); check("R1 srclen", rv, 0);
        check("R1 irq", irq, 0);
        check("R1 mem_req", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: one block per entry, one cell covering it
        for (int v = 0; v < 7; v++) begin
            fill();
            setup(VEC[v].sl, VEC[v].dl, 12'd32, VEC[v].pat);
            wr(4'd8, 16'h0002);
            tag = VEC[v].pe ? "R4" : ((VEC[v].sl != VEC[v].dl) ? "R3" : "R5");
            wr(4'd0, {11'd0, 1'b0, 1'b1, VEC[v].pe, 1'b0, 1'b1});
            repeat (2 * VEC[v].nexp) @(negedge clk);
            rd(4'd7, rv); check({tag, " R2 flag not yet"}, rv[1], 0);
            check({tag, " irq early"}, irq, 0);
            @(negedge clk);
            rd(4'd7, rv); check({tag, " R3 block+cell flag"}, rv[1:0], 2'b11);
            check({tag, " R11 irq"}, irq, 1);
            rd(4'd0, rv); check({tag, " R6 enable cleared"}, rv[0], 0);
            for (int i = 0; i < 16; i++) expd[i] = 8'hEE;
            for (int k = 0; k < int'(VEC[v].nexp); k++)
                expd[k % int'(VEC[v].dl)] = srcval(k % int'(VEC[v].sl));
            mism = 0;
            for (int i = 0; i < 16; i++) if (mem[DBASE[7:0] + 8'(i)] !== expd[i]) mism++;
            check({tag, " destination bytes"}, mism, 0);
        end

        // R7 / R12: multi-cell block, trigger during busy cell
        fill();
        setup(12'd6, 12'd6, 12'd2, 8'h00);
        wr(4'd8, 16'h0000);
        wr(4'd0, 16'h0009);
        wr(4'd0, 16'h0009);
        repeat (3) @(negedge clk);
        rd(4'd7, rv); check("R7 cell flag not yet", rv[0], 0);
        check("R11 irq masked", irq, 0);
        @(negedge clk);
        rd(4'd7, rv); check("R7 cell flag only", rv[1:0], 2'b01);
        rd(4'd0, rv); check("R7 enable kept", rv[0], 1);
        repeat (10) @(negedge clk);
        check("R12 no queued cell", mem[DBASE[7:0] + 8'd2], 8'hEE);
        check("R12 idle", mem_req, 0);
        wr(4'd0, 16'h0009); repeat (8) @(negedge clk);
        rd(4'd7, rv); check("R7 second cell no block", rv[1], 0);
        wr(4'd0, 16'h0009); repeat (8) @(negedge clk);
        rd(4'd7, rv); check("R7 block after third cell", rv[1], 1);
        check("R7 last byte", mem[DBASE[7:0] + 8'd5], srcval(5));

        // R11: write-one-to-clear
        wr(4'd7, 16'h0001);
        rd(4'd7, rv); check("R11 w1c keeps other bit", rv[2:0], 3'b010);

        // R6 / R9: auto-rearm and shadowed configuration
        fill();
        setup(12'd2, 12'd2, 12'd8, 8'h00);
        wr(4'd0, 16'h000B);
        repeat (6) @(negedge clk);
        rd(4'd7, rv); check("R6 auto block done", rv[1], 1);
        rd(4'd0, rv); check("R6 auto keeps enable", rv[0], 1);
        wr(4'd4, 16'd5); wr(4'd5, 16'd5);
        wr(4'd1, 16'h0021); wr(4'd0, 16'h0007);
        fill();
        wr(4'd7, 16'h0007);
        wr(4'd0, 16'h000B);
        repeat (4) @(negedge clk);
        rd(4'd7, rv); check("R9 not yet", rv[1], 0);
        @(negedge clk);
        rd(4'd7, rv); check("R9 old length used", rv[1], 1);
        check("R6 restart at start address", mem[DBASE[7:0]], srcval(0));
        check("R9 length ignored while enabled", mem[DBASE[7:0] + 8'd2], 8'hEE);
        rd(4'd4, rv); check("R9 programmed readback", rv, 5);

        // R8: hardware start event
        wr(4'd0, 16'h0000);
        fill();
        setup(12'd3, 12'd3, 12'd16, 8'h00);
        wr(4'd0, 16'h0001);
        start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
        repeat (10) @(negedge clk);
        check("R8 event ignored when off", mem[DBASE[7:0]], 8'hEE);
        rd(4'd7, rv); check("R8 no flag when off", rv, 0);
        wr(4'd0, 16'h0011);
        start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
        repeat (5) @(negedge clk);
        rd(4'd7, rv); check("R8 not yet", rv[1], 0);
        @(negedge clk);
        rd(4'd7, rv); check("R8 block via event", rv[1], 1);

        // R10: abort mid-cell
        wr(4'd0, 16'h0000);
        fill();
        setup(12'd40, 12'd40, 12'd64, 8'h00);
        wr(4'd8, 16'h0002);
        wr(4'd0, 16'h0009);
        repeat (6) @(negedge clk);
        wr(4'd0, 16'h0000);
        check("R10 request dropped", mem_req, 0);
        @(negedge clk);
        rd(4'd7, rv); check("R10 abort flag", rv[2:0], 3'b100);
        check("R11 abort masked", irq, 0);
        check("R10 transfer stopped", mem[DBASE[7:0] + 8'd20], 8'hEE);
        wr(4'd8, 16'h0004);
        check("R11 abort unmasked", irq, 1);
        wr(4'd7, 16'h0004);
        rd(4'd7, rv); check("R11 cleared", rv, 0);
        check("R11 irq low after clear", irq, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule